// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a 16-bit successive-approximation converter, with the analog section abstracted away. A host requests a sample by pulling the active-low start input low. The block brings that request into its clock domain, raises a busy flag, and times a fixed conversion interval in system clocks. At the end of the interval it captures the word presented on the comparator-result port into the output register, then drops busy. There is no pipeline, so the word captured by a conversion is on the output as soon as busy falls.

The sequencer enforces a minimum spacing between accepted starts. It drops start requests that arrive while a conversion is running or while the power-down input is high. A reset aborts any conversion and clears the output. A coding input chooses between straight binary and twos complement. In twos complement the top bit is inverted. Both the interval length and the spacing are parameters counted in clock cycles. The defaults, 145 and 400, give about 1.45 µs and 4 µs at 100 MHz.

Top module: `sar_conv_seq`

## Requirements
- R1: A falling edge on `cnv_n` passes through a two-stage synchroniser. Let E0 be the first rising clock edge at which `cnv_n` is low. `busy` is still low after E1 and is high after E2, provided the start is accepted.
- R2: Once an accepted start raises `busy`, `busy` stays high for exactly CONV_CYC+1 clock cycles.
- R3: `result` is loaded on the last clock edge at which `busy` is still high. It takes the value `cmp_word` has at that edge, not the value it had at the start. At every other edge `result` holds its value.
- R4: With `bin_sel` = 1 at the capture edge, `result` equals `cmp_word`. With `bin_sel` = 0, bit DATA_W-1 of `cmp_word` is inverted and all lower bits pass unchanged.
- R5: A start edge that arrives while `busy` is high is dropped, not queued. After that conversion ends, `busy` stays low until a new edge arrives.
- R6: Let a start be accepted at edge Ea. A start whose decision edge is earlier than Ea+SPACE_CYC is dropped. A start whose decision edge is at or after Ea+SPACE_CYC is accepted. A dropped edge does not restart the spacing.
- R7: A start edge is dropped while `pwr_dn` is high. A conversion already running when `pwr_dn` rises completes with the normal length and a correct result.
- R8: While `rst` is high, on each clock edge any conversion is aborted, `busy` goes low and `result` goes to all zeros. This is also the state after power-up reset.
- R9: After `rst` is released, the first start edge is accepted at once, without waiting out the spacing interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; aborts any conversion |
| cnv_n | input | 1 | Active-low conversion request; a falling edge starts a conversion |
| pwr_dn | input | 1 | High blocks new conversions; a running one finishes |
| bin_sel | input | 1 | 1: straight binary, 0: twos complement (top bit inverted) |
| cmp_word | input | DATA_W | Stand-in for the comparator decision word |
| busy | output | 1 | High from accepted start until the result is loaded |
| result | output | DATA_W | Last converted word in the selected coding |

## Verification
The hardest condition to reach from the ports is a start edge whose decision lands one cycle short of the spacing limit, next to one that lands exactly on it. Both are produced by counting falling clock edges from the request that launched the previous conversion. A request issued SPACE_CYC-1 edges later must be dropped, and one issued SPACE_CYC edges later must be accepted. A second hard case is a request that arrives during a conversion, so the bench checks that `busy` stays low for a full spacing interval afterwards, which would expose a queued start. The last is a reset in the middle of a conversion, followed at once by a new request that must not wait out the spacing.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CONV = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_t;

   function automatic int unsigned width_for(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic req_n,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b1;
               else     chain_q[0] <= req_n;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b1;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b1;
      else     last_q <= chain_q[STAGES-1];
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sar_interval_timer.sv
module sar_interval_timer
   import sar_seq_pkg::*;
#(
   parameter int CONV_CYC  = 145,
   parameter int SPACE_CYC = 400
) (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   output logic conv_last_o,
   output logic gap_ok_o
);

   localparam int CNT_W = width_for(CONV_CYC);
   localparam int SP_W  = width_for(SPACE_CYC);
   // spacing is already implied by the state sequence when it is this short
   localparam bit NEED_GAP = (SPACE_CYC > CONV_CYC + 2);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         cnt_q <= CNT_W'(CONV_CYC - 1);
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign conv_last_o = run_q && (cnt_q == '0);

   generate
      if (NEED_GAP) begin : g_gap_counter
         logic [SP_W-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (rst)               gap_q <= '0;
            else if (load_i)       gap_q <= SP_W'(SPACE_CYC - 1);
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
         end
         assign gap_ok_o = (gap_q == '0);
      end else begin : g_gap_implied
         assign gap_ok_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_i,
   input  logic              bin_sel,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int TOP = DATA_W - 1;

   logic [DATA_W-1:0] coded;

   always_comb begin
      coded = word_i;
      if (!bin_sel) coded[TOP] = ~word_i[TOP];
   end

   always_ff @(posedge clk) begin
      if (rst)        result_o <= '0;
      else if (cap_i) result_o <= coded;
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CONV_CYC    = 145,
   parameter int SPACE_CYC   = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnv_n,
   input  logic              pwr_dn,
   input  logic              bin_sel,
   input  logic [DATA_W-1:0] cmp_word,
   output logic              busy,
   output logic [DATA_W-1:0] result
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sar_conv_seq: DATA_W must be at least 2");
      end
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("sar_conv_seq: CONV_CYC must be at least 1");
      end
      if (SPACE_CYC < 1) begin : g_bad_space
         $error("sar_conv_seq: SPACE_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sar_conv_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   seq_state_t state_q;
   logic       busy_q;
   logic       start_fall;
   logic       gap_ok;
   logic       conv_last;
   logic       start_ok;
   logic       cap_en;

   sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .req_n  (cnv_n),
      .fall_o (start_fall)
   );

   sar_interval_timer #(.CONV_CYC(CONV_CYC), .SPACE_CYC(SPACE_CYC)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .load_i      (start_ok),
      .conv_last_o (conv_last),
      .gap_ok_o    (gap_ok)
   );

   sar_result_reg #(.DATA_W(DATA_W)) u_result (
      .clk      (clk),
      .rst      (rst),
      .cap_i    (cap_en),
      .bin_sel  (bin_sel),
      .word_i   (cmp_word),
      .result_o (result)
   );

   always_comb begin
      start_ok = (state_q == SEQ_IDLE) && start_fall && gap_ok && !pwr_dn;
      cap_en   = (state_q == SEQ_CONV) && conv_last;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         busy_q  <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start_ok) begin
                  state_q <= SEQ_CONV;
                  busy_q  <= 1'b1;
               end
            end
            SEQ_CONV: begin
               if (conv_last) state_q <= SEQ_DONE;
            end
            SEQ_DONE: begin
               busy_q  <= 1'b0;
               state_q <= SEQ_IDLE;
            end
            default: begin
               state_q <= SEQ_IDLE;
               busy_q  <= 1'b0;
            end
         endcase
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int DATA_W    = 16,
   parameter int CONV_CYC  = 145,
   parameter int SPACE_CYC = 400
) (
   input logic              clk,
   input logic              rst,
   input logic              pwr_dn,
   input logic              busy,
   input logic [DATA_W-1:0] result,
   input logic              cap_en
);

   int   busy_run;
   int   gap_cnt;
   logic busy_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_run <= 0;
         gap_cnt  <= SPACE_CYC;
         busy_d   <= 1'b0;
      end else begin
         busy_d <= busy;
         if (busy) busy_run <= busy_run + 1;
         else      busy_run <= 0;
         if (busy && !busy_d)      gap_cnt <= 1;
         else if (gap_cnt < SPACE_CYC) gap_cnt <= gap_cnt + 1;
      end
   end

   assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> (busy_run == CONV_CYC + 1));

   assert_cap_before_fall_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> $past(cap_en, 2));

   assert_result_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(cap_en) && !$past(rst)) |-> $stable(result));

   assert_pd_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !$past(pwr_dn));

   assert_spacing_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (gap_cnt >= SPACE_CYC));

   assert_reset_clear_R8: assert property (@(posedge clk)
      $past(rst) |-> (!busy && result == '0));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
   .DATA_W    (DATA_W),
   .CONV_CYC  (CONV_CYC),
   .SPACE_CYC (SPACE_CYC)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pwr_dn (pwr_dn),
   .busy   (busy),
   .result (result),
   .cap_en (cap_en)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

   localparam int CLK_P = 10;
   localparam int W     = 16;
   localparam int C     = 145;
   localparam int S     = 400;

   logic         clk;
   logic         rst;
   logic         cnv_n;
   logic         pwr_dn;
   logic         bin_sel;
   logic [W-1:0] cmp_word;
   logic         busy;
   logic [W-1:0] result;

   int checks = 0;
   int fails  = 0;

   sar_conv_seq #(.DATA_W(W), .CONV_CYC(C), .SPACE_CYC(S), .SYNC_STAGES(2)) dut (
      .clk      (clk),
      .rst      (rst),
      .cnv_n    (cnv_n),
      .pwr_dn   (pwr_dn),
      .bin_sel  (bin_sel),
      .cmp_word (cmp_word),
      .busy     (busy),
      .result   (result)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // after a conversion returns (at request + C + 4), reach request + S
   task automatic wait_gap();
      wait_neg(S - 4 - C);
   endtask

   // mode 0 plain, 1 extra request mid-conversion, 2 power-down mid-conversion,
   // 3 comparator word only valid just before capture
   task automatic do_conv(input logic [W-1:0] w, input bit bs, input int mode, input string tag);
      logic [W-1:0] expv;
      logic [W-1:0] prev;
      int n;
      int chg;
      expv     = bs ? w : {~w[W-1], w[W-2:0]};
      bin_sel  = bs;
      cmp_word = (mode == 3) ? ~w : w;
      cnv_n    = 1'b0;
      @(negedge clk);
      @(negedge clk);
      cnv_n = 1'b1;
      chk({tag, ": R1 busy low after second edge"}, busy, 0);
      @(negedge clk);
      chk({tag, ": R1 busy high after third edge"}, busy, 1);
      n    = 1;
      chg  = 0;
      prev = result;
      while (n < C + 20) begin
         @(negedge clk);
         if (!busy) break;
         n++;
         if (mode == 3 && n == C)  cmp_word = w;
         if (mode == 1 && n == 10) cnv_n = 1'b0;
         if (mode == 1 && n == 12) cnv_n = 1'b1;
         if (mode == 2 && n == 20) pwr_dn = 1'b1;
         if (result !== prev) chg = n;
         prev = result;
      end
      chk({tag, ": R2 busy length"}, n, C + 1);
      chk({tag, ": R3 result loads on last busy cycle"}, chg, C + 1);
      chk({tag, ": R4 result value"}, result, expv);
   endtask

   task automatic pulse_ignored(input string msg);
      int bad;
      cnv_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      cnv_n = 1'b1;
      bad = 0;
      repeat (6) begin
         @(negedge clk);
         if (busy) bad++;
      end
      chk(msg, bad, 0);
   endtask

   task automatic t_reset_state();
      rst = 1'b1; cnv_n = 1'b1; pwr_dn = 1'b0; bin_sel = 1'b1; cmp_word = '0;
      wait_neg(3);
      chk("R8 busy low in reset", busy, 0);
      chk("R8 result zero in reset", result, 0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_coding();
      logic [W-1:0] held;
      do_conv(16'h1234, 1'b1, 0, "straight binary");
      held = result;
      cmp_word = 16'hDEAD;
      wait_neg(5);
      chk("R3 result holds after conversion", result, held);
      wait_neg(S - 9 - C);
      do_conv(16'h1234, 1'b0, 0, "twos complement positive");
      wait_gap();
      do_conv(16'hF00F, 1'b0, 0, "twos complement negative");
   endtask

   task automatic t_late_word();
      wait_gap();
      do_conv(16'h0F0F, 1'b1, 3, "R3 word sampled at capture");
   endtask

   task automatic t_busy_ignore();
      int bad;
      wait_gap();
      do_conv(16'h8001, 1'b1, 1, "R5 request during busy");
      bad = 0;
      repeat (S) begin
         @(negedge clk);
         if (busy) bad++;
      end
      chk("R5 request during busy not queued", bad, 0);
   endtask

   task automatic t_spacing();
      do_conv(16'h7FFE, 1'b0, 0, "R6 spacing base");
      wait_neg(S - 5 - C);
      pulse_ignored("R6 request one cycle early dropped");
      do_conv(16'h4321, 1'b1, 0, "R6 dropped request did not restart spacing");
      wait_gap();
      do_conv(16'hABCD, 1'b1, 0, "R6 exact spacing accepted");
   endtask

   task automatic t_power_down();
      wait_gap();
      pwr_dn = 1'b1;
      pulse_ignored("R7 request dropped in power-down");
      pwr_dn = 1'b0;
      do_conv(16'hC3C3, 1'b0, 2, "R7 running conversion completes");
      wait_gap();
      pulse_ignored("R7 request dropped after power-down rose");
      pwr_dn = 1'b0;
   endtask

   task automatic t_reset_abort();
      wait_gap();
      cmp_word = 16'h1111;
      cnv_n = 1'b0;
      wait_neg(2);
      cnv_n = 1'b1;
      wait_neg(30);
      chk("R8 conversion running before reset", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 busy cleared by reset", busy, 0);
      chk("R8 result zeroed by reset", result, 0);
      rst = 1'b0;
      do_conv(16'h5A5A, 1'b1, 0, "R9 start right after reset");
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_coding();
      t_late_word();
      t_busy_ignore();
      t_spacing();
      t_power_down();
      t_reset_abort();
      wait_neg(5);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule